// File: doc/BRIEF.md
# Bit-Field Deposit Unit

This execution unit writes a bit field into a 32-bit word. Each accepted instruction picks the field source: either a register value or a five-bit signed immediate. It also picks the field position: either a shift-amount register or an immediate in the instruction. The bits outside the field are taken from the current target register value, or they are cleared to zero. The unit can also raise a flag that asks the pipeline to squash the next instruction when a condition on the deposited word holds.

The pipeline provides the instruction word, the source register value, the current target register value, the shift-amount register and a valid strobe. One cycle after a valid strobe carrying the unit's major opcode, the unit presents the target register index, the result word, a write enable and the nullify-next flag. Register file access and pipeline control are handled elsewhere.

Top module: `bit_deposit_unit`

## Requirements
- R1: A valid strobe whose instruction bits 31..26 equal 6'b110101 raises `wr_en_o` on the next cycle, and `tgt_idx_o` then equals instruction bits 25..21. Any other cycle leaves `wr_en_o` low on the next cycle.
- R2: Instruction bits 12..11 select the form. 2'b00 is register value at shift-amount position, 2'b01 is register value at immediate position, 2'b10 is immediate value at shift-amount position, and 2'b11 is immediate value at immediate position. The register value is `src_i`.
- R3: The immediate is instruction bits 20..16. Bit 16 is the sign and bits 20..17 are the low four bits. The five-bit two's-complement value {bit16, bits20..17} is sign-extended to 32 bits. For example, 5'b00001 decodes to -16 and 5'b11110 decodes to +15.
- R4: In immediate-position forms, the field's least significant bit lands at bit `cpos` (instruction bits 9..5). The field length is 32 minus `clen` (bits 4..0). When `cpos` plus the length exceeds 32, the length is cut to 32 minus `cpos`.
- R5: In shift-amount forms, the field's least significant bit lands at bit (`sar_i` XOR 31). Field bits that would fall above bit 31 are dropped.
- R6: When instruction bit 10 (merge flag) is 1, result bits outside the field equal `tgt_i`. When it is 0, those bits are zero.
- R7: The condition in bits 15..13 is evaluated on the result, and `nullify_o` is raised with the write when it holds. The codes are: 0 never, 1 result zero, 2 result negative, 3 result odd, 4 always, 5 result nonzero, 6 result not negative, 7 result even.
- R8: After reset all outputs are zero. `result_o` and `tgt_idx_o` keep their value in any cycle that follows no accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word |
| src_i | input | 32 | Source register value |
| tgt_i | input | 32 | Current target register value |
| sar_i | input | 5 | Shift-amount register |
| wr_en_o | output | 1 | Target write enable |
| tgt_idx_o | output | 5 | Target register index |
| result_o | output | 32 | Deposited word |
| nullify_o | output | 1 | Squash the next instruction |

## Verification
The bench builds the unit with its default 32-bit word. At that width every field position 0..31 and every length code 0..31 can be driven, which covers both the single-bit fields at the top and bottom of the word and the clamped fields that run past bit 31. A behavioural bit-by-bit model in the bench is compared against the outputs on every clock. Directed cases target the immediate sign encoding, the clamp, both merge settings and all eight condition codes. A long random stream then covers opcode misses and idle cycles.

// File: rtl/dep_pkg.sv
package dep_pkg;
  localparam logic [5:0] DEP_OPCODE = 6'b110101;

  typedef enum logic [1:0] {
    FORM_REG_SAR = 2'b00,
    FORM_REG_IMM = 2'b01,
    FORM_IMM_SAR = 2'b10,
    FORM_IMM_IMM = 2'b11
  } dep_form_e;

  typedef enum logic [2:0] {
    COND_NEVER = 3'd0,
    COND_ZERO  = 3'd1,
    COND_NEG   = 3'd2,
    COND_ODD   = 3'd3,
    COND_TRUE  = 3'd4,
    COND_NZERO = 3'd5,
    COND_NNEG  = 3'd6,
    COND_EVEN  = 3'd7
  } dep_cond_e;
endpackage

// File: rtl/dep_decode.sv
module dep_decode
  import dep_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W),
  parameter int LEN_W  = POS_W + 1
) (
  input  logic [31:0]       insn_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [POS_W-1:0]  sar_i,
  output logic              hit_o,
  output logic [4:0]        t_idx_o,
  output dep_cond_e         cond_o,
  output logic              merge_o,
  output logic [POS_W-1:0]  pos_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DATA_W-1:0] value_o
);
  localparam logic [POS_W-1:0] POS_FLIP = POS_W'(DATA_W - 1);

  dep_form_e         form;
  logic [4:0]        imm_raw;
  logic [4:0]        imm_tc;
  logic [DATA_W-1:0] imm_ext;

  assign hit_o   = insn_i[31:26] == DEP_OPCODE;
  assign t_idx_o = insn_i[25:21];
  assign cond_o  = dep_cond_e'(insn_i[15:13]);
  assign merge_o = insn_i[10];
  assign form    = dep_form_e'(insn_i[12:11]);

  // sign sits in the lowest immediate bit
  assign imm_raw = insn_i[20:16];
  assign imm_tc  = {imm_raw[0], imm_raw[4:1]};
  assign imm_ext = {{(DATA_W-5){imm_tc[4]}}, imm_tc};

  always_comb begin
    value_o = src_i;
    pos_o   = sar_i ^ POS_FLIP;
    unique case (form)
      FORM_REG_SAR: begin value_o = src_i;   pos_o = sar_i ^ POS_FLIP;    end
      FORM_REG_IMM: begin value_o = src_i;   pos_o = POS_W'(insn_i[9:5]); end
      FORM_IMM_SAR: begin value_o = imm_ext; pos_o = sar_i ^ POS_FLIP;    end
      FORM_IMM_IMM: begin value_o = imm_ext; pos_o = POS_W'(insn_i[9:5]); end
      default: ;
    endcase
  end

  assign len_o = LEN_W'(DATA_W) - LEN_W'(insn_i[4:0]);
endmodule

// File: rtl/dep_mask_gen.sv
module dep_mask_gen #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W),
  parameter int LEN_W  = POS_W + 1
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam int END_W = LEN_W + 1;

  logic [END_W-1:0] field_end;
  assign field_end = END_W'(pos_i) + END_W'(len_i);

  // bits at or above the word edge simply do not exist: implicit clamp
  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    assign mask_o[k] = (END_W'(k) >= END_W'(pos_i)) && (END_W'(k) < field_end);
  end
endmodule

// File: rtl/dep_cond.sv
module dep_cond
  import dep_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  dep_cond_e         cond_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              true_o
);
  logic is_zero, is_neg, is_odd;

  assign is_zero = ~|word_i;
  assign is_neg  = word_i[DATA_W-1];
  assign is_odd  = word_i[0];

  always_comb begin
    unique case (cond_i)
      COND_NEVER: true_o = 1'b0;
      COND_ZERO:  true_o = is_zero;
      COND_NEG:   true_o = is_neg;
      COND_ODD:   true_o = is_odd;
      COND_TRUE:  true_o = 1'b1;
      COND_NZERO: true_o = ~is_zero;
      COND_NNEG:  true_o = ~is_neg;
      COND_EVEN:  true_o = ~is_odd;
      default:    true_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bit_deposit_unit.sv
module bit_deposit_unit
  import dep_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       insn_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] tgt_i,
  input  logic [4:0]        sar_i,
  output logic              wr_en_o,
  output logic [4:0]        tgt_idx_o,
  output logic [DATA_W-1:0] result_o,
  output logic              nullify_o
);
  localparam int POS_W = $clog2(DATA_W);
  localparam int LEN_W = POS_W + 1;

  logic              hit, merge, cond_true, accept;
  logic [4:0]        t_idx;
  dep_cond_e         cond;
  logic [POS_W-1:0]  pos;
  logic [LEN_W-1:0]  len;
  logic [DATA_W-1:0] value, mask, placed, base, merged;

  dep_decode #(.DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_decode (
    .insn_i  (insn_i),
    .src_i   (src_i),
    .sar_i   (POS_W'(sar_i)),
    .hit_o   (hit),
    .t_idx_o (t_idx),
    .cond_o  (cond),
    .merge_o (merge),
    .pos_o   (pos),
    .len_o   (len),
    .value_o (value)
  );

  dep_mask_gen #(.DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_mask (
    .pos_i  (pos),
    .len_i  (len),
    .mask_o (mask)
  );

  assign placed = value << pos;
  assign base   = merge ? tgt_i : '0;
  assign merged = (placed & mask) | (base & ~mask);
  assign accept = valid_i & hit;

  dep_cond #(.DATA_W(DATA_W)) u_cond (
    .cond_i (cond),
    .word_i (merged),
    .true_o (cond_true)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      nullify_o <= 1'b0;
      tgt_idx_o <= '0;
      result_o  <= '0;
    end else begin
      wr_en_o   <= accept;
      nullify_o <= accept & cond_true;
      if (accept) begin
        tgt_idx_o <= t_idx;
        result_o  <= merged;
      end
    end
  end
endmodule

// File: rtl/bit_deposit_unit_chk.sv
module bit_deposit_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [31:0]       insn_i,
  input logic              wr_en_o,
  input logic [4:0]        tgt_idx_o,
  input logic [DATA_W-1:0] result_o,
  input logic              nullify_o
);
  logic hit;
  assign hit = valid_i && (insn_i[31:26] == 6'b110101);

  a_r1_write_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> wr_en_o);
  a_r1_quiet_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> !wr_en_o);
  a_r1_target_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> tgt_idx_o == $past(insn_i[25:21]));
  a_r6_zero_below_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !insn_i[10] && insn_i[11] && insn_i[9:5] != 5'd0) |=> !result_o[0]);
  a_r7_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && insn_i[15:13] == 3'd0) |=> !nullify_o);
  a_r7_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && insn_i[15:13] == 3'd4) |=> nullify_o);
  a_r7_zero_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && insn_i[15:13] == 3'd1) |=> nullify_o == (result_o == '0));
  a_r7_null_with_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nullify_o |-> wr_en_o);
  a_r8_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(result_o) && $stable(tgt_idx_o));
endmodule

bind bit_deposit_unit bit_deposit_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .insn_i    (insn_i),
  .wr_en_o   (wr_en_o),
  .tgt_idx_o (tgt_idx_o),
  .result_o  (result_o),
  .nullify_o (nullify_o)
);

// File: tb/bit_deposit_unit_bench.sv
module bit_deposit_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] insn = '0, src = '0, tgt = '0;
  logic [4:0]  sar = '0;
  logic        wr_en, nullify;
  logic [4:0]  tgt_idx;
  logic [31:0] result;

  int checks = 0, fails = 0, cycles = 0;
  string cur_tag = "R8";

  logic        exp_wr = 1'b0, exp_null = 1'b0;
  logic [4:0]  exp_idx = '0;
  logic [31:0] exp_res = '0;

  always #5 clk = ~clk;

  bit_deposit_unit u_bit_deposit_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn),
    .src_i(src), .tgt_i(tgt), .sar_i(sar), .wr_en_o(wr_en),
    .tgt_idx_o(tgt_idx), .result_o(result), .nullify_o(nullify)
  );

  function automatic logic [31:0] mk(input int form, input int t, input int r,
                                     input int c, input int nz, input int cpos,
                                     input int clen);
    logic [31:0] w;
    w = '0;
    w[31:26] = 6'b110101;
    w[25:21] = 5'(t);  w[20:16] = 5'(r);  w[15:13] = 3'(c);
    w[12:11] = 2'(form); w[10] = nz[0]; w[9:5] = 5'(cpos); w[4:0] = 5'(clen);
    return w;
  endfunction

  function automatic void ref_calc(input logic [31:0] in, input logic [31:0] s,
                                   input logic [31:0] t, input logic [4:0] sa,
                                   output logic [31:0] res, output logic nul);
    int imm, pos, len, c;
    logic [31:0] val;
    imm = int'(in[20:17]) - (in[16] ? 16 : 0);
    val = in[12] ? 32'(imm) : s;
    pos = in[11] ? int'(in[9:5]) : 31 - int'(sa);
    len = 32 - int'(in[4:0]);
    for (int k = 0; k < 32; k++) begin
      if (k >= pos && k < pos + len) res[k] = val[k - pos];
      else res[k] = in[10] ? t[k] : 1'b0;
    end
    c = int'(in[15:13]);
    case (c)
      0: nul = 0;
      1: nul = (res == 0);
      2: nul = res[31];
      3: nul = res[0];
      4: nul = 1;
      5: nul = (res != 0);
      6: nul = !res[31];
      default: nul = !res[0];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] r;
    logic n;
    if (!rst_n) begin
      exp_wr <= 0; exp_null <= 0; exp_idx <= '0; exp_res <= '0;
    end else begin
      if (valid && insn[31:26] == 6'b110101) begin
        ref_calc(insn, src, tgt, sar, r, n);
        exp_wr <= 1; exp_null <= n; exp_idx <= insn[25:21]; exp_res <= r;
      end else begin
        exp_wr <= 0; exp_null <= 0;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks += 4;
      if (wr_en !== exp_wr) begin
        fails++; $display("FAIL R1 wr_en act=%0b exp=%0b", wr_en, exp_wr);
      end
      if (tgt_idx !== exp_idx) begin
        fails++; $display("FAIL R1 tgt_idx act=%0d exp=%0d", tgt_idx, exp_idx);
      end
      if (result !== exp_res) begin
        fails++; $display("FAIL %s result act=%h exp=%h", cur_tag, result, exp_res);
      end
      if (nullify !== exp_null) begin
        fails++; $display("FAIL R7 nullify act=%0b exp=%0b", nullify, exp_null);
      end
    end
  end

  task automatic drive(input logic v, input logic [31:0] in, input logic [31:0] s,
                       input logic [31:0] t, input logic [4:0] sa, input string tag);
    @(negedge clk);
    #1;
    cur_tag = tag;
    valid = v; insn = in; src = s; tgt = t; sar = sa;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R8 reset state
    if (wr_en !== 0 || nullify !== 0 || result !== 0 || tgt_idx !== 0) begin
      fails++; $display("FAIL R8 reset act=%b%b%h exp=0", wr_en, nullify, result);
    end
    rst_n = 1'b1;
    // R2 form 00, R5 sar=0 puts one bit at 31, sar=31 at bit 0
    drive(1, mk(0, 3, 1, 0, 0, 0, 0), 32'h1234_5679, 32'hFFFF_FFFF, 5'd0, "R5");
    drive(1, mk(0, 4, 1, 0, 1, 0, 0), 32'hDEAD_BEEF, 32'h0F0F_0F0F, 5'd31, "R5");
    drive(1, mk(0, 5, 1, 0, 1, 0, 24), 32'h0000_00A5, 32'h5555_5555, 5'd19, "R5");
    // R4 immediate position, clamp at word edge
    drive(1, mk(1, 6, 2, 0, 0, 28, 0), 32'hFFFF_FFF9, 32'h0, 5'd0, "R4");
    drive(1, mk(1, 7, 2, 0, 1, 8, 24), 32'h0000_0033, 32'hAAAA_AAAA, 5'd0, "R4");
    drive(1, mk(1, 8, 2, 0, 1, 0, 0), 32'h8765_4321, 32'h0, 5'd0, "R4");
    // R3 immediate sign in low bit
    drive(1, mk(3, 9, 5'b00001, 0, 0, 0, 27), 32'h0, 32'h0, 5'd0, "R3");
    drive(1, mk(3, 9, 5'b11110, 0, 0, 4, 0), 32'h0, 32'h0, 5'd0, "R3");
    drive(1, mk(2, 10, 5'b11111, 0, 1, 0, 28), 32'h0, 32'h1357_9BDF, 5'd15, "R3");
    // R6 merge versus zero base
    drive(1, mk(1, 11, 0, 0, 1, 12, 24), 32'h0000_00FF, 32'hCAFE_F00D, 5'd0, "R6");
    drive(1, mk(1, 11, 0, 0, 0, 12, 24), 32'h0000_00FF, 32'hCAFE_F00D, 5'd0, "R6");
    // R8 idle and opcode miss keep result
    drive(0, mk(1, 12, 0, 4, 0, 0, 0), 32'h1, 32'h2, 5'd0, "R8");
    drive(1, 32'hD000_0000, 32'h3, 32'h4, 5'd0, "R8");
    // R7 all condition codes, zero and nonzero words
    for (int c = 0; c < 8; c++) begin
      drive(1, mk(1, c, 0, c, 0, 0, 0), 32'h0, 32'h0, 5'd0, "R7");
      drive(1, mk(1, c, 0, c, 0, 0, 0), 32'h8000_0001, 32'h0, 5'd0, "R7");
      drive(1, mk(1, c, 0, c, 0, 0, 0), 32'h0000_0002, 32'h0, 5'd0, "R7");
    end
    // random stream
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom_range(0, 9) != 0) w[31:26] = 6'b110101;
      drive($urandom_range(0, 7) != 0, w, $urandom, $urandom, 5'($urandom), "R2");
    end
    drive(0, '0, '0, '0, '0, "R8");
    repeat (2) @(negedge clk);
    #2;
    finish_run();
  end

  initial begin
    wait (cycles > 20000);
    fails++; checks++;
    $display("FAIL R1 watchdog act=%0d exp<20000", cycles);
    finish_run();
  end
endmodule